// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a small binary counter that steps on two separate count strobes: one strobe moves the value up, the other moves it down. The strobes are treated as slow level signals. Each one passes through a two-flop synchronizer and a rising-edge detector that run on a free-running system clock, so the whole block is synchronous. A level-sensitive clear and an active-low parallel preset override counting. Clear wins over preset.

Two active-low terminal outputs follow the synchronized strobe levels. The carry output pulses low while the count sits at its maximum and the up strobe is low. The borrow output does the same at zero while the down strobe is low. Each terminal output rises again in the same system cycle that the counter leaves its terminal value. Because of this, the terminal outputs can drive the strobe inputs of a following stage, and stages chain into wider ripple counters. If both strobes show a rising edge in the same cycle, the count holds and a sticky fault flag is raised.

Top module: `dual_clock_counter`

## Requirements
- R1: After the system reset `rst_n` is released, `count_o` is 0, `carry_n_o` and `borrow_n_o` are 1 and `fault_o` is 0.
- R2: While `dn_strobe_i` is held high, each rising edge of `up_strobe_i` raises `count_o` by one, and the count wraps from 15 to 0. The new value is visible at most three system clock edges after the input edge.
- R3: While `up_strobe_i` is held high, each rising edge of `dn_strobe_i` lowers `count_o` by one, and the count wraps from 0 to 15.
- R4: While `clear_i` (active high) is 1, `count_o` becomes 0 on the next system clock edge. This happens whatever the state of the strobes and of `load_n_i`.
- R5: While `load_n_i` (active low) is 0 and `clear_i` is 0, `count_o` takes the value of `data_i` on the next system clock edge. Strobe edges during this time have no effect.
- R6: `carry_n_o` is 0 exactly when `count_o` is 15 and the synchronized up strobe is low. Otherwise it is 1.
- R7: `borrow_n_o` is 0 exactly when `count_o` is 0 and the synchronized down strobe is low. Otherwise it is 1.
- R8: If a strobe is low during a clear or preset and stays low after release, its next rising edge is counted.
- R9: If both strobes rise in the same system cycle, `count_o` is left unchanged and `fault_o` goes to 1. It stays at 1 until `rst_n` is asserted.
- R10: When `carry_n_o` and `borrow_n_o` of one stage drive `up_strobe_i` and `dn_strobe_i` of a second stage, the pair counts as one 8-bit counter in both directions, including wrap at 255/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low system reset |
| up_strobe_i | input | 1 | Count-up strobe (level, asynchronous) |
| dn_strobe_i | input | 1 | Count-down strobe (level, asynchronous) |
| clear_i | input | 1 | Active-high master clear |
| load_n_i | input | 1 | Active-low parallel preset |
| data_i | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low terminal count up |
| borrow_n_o | output | 1 | Active-low terminal count down |
| fault_o | output | 1 | Sticky flag for simultaneous strobe edges |

## Verification
The bench sweeps a two-stage chain through more than a full 8-bit cycle upward and then downward, comparing it against an arithmetic model. A stage whose terminal output rises one cycle late, or does not rise at all, shows up as a wrong upper nibble at the 15→0 and 0→15 crossings. A design that throws away edges seen during clear or preset would lose the first count after a release with the strobe held low. A design that counted one direction during a strobe collision would be caught by a count that moved while the fault flag was set. A design that let preset beat clear would be caught when both are asserted together.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_INC,
        ACT_DEC,
        ACT_CLASH
    } dcc_act_e;
endpackage

// File: rtl/dcc_edge_sync.sv
`timescale 1ns/1ps
module dcc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.last;
    assign level_o = st_q.last;
endmodule

// File: rtl/dcc_count_core.sv
`timescale 1ns/1ps
module dcc_count_core
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             up_rise_i,
    input  logic             dn_rise_i,
    output logic [WIDTH-1:0] count_o,
    output logic             fault_o
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             fault;
    } core_t;

    core_t    st_d, st_q;
    dcc_act_e act;

    always_comb begin
        if (clear_i)                  act = ACT_CLEAR;
        else if (!load_n_i)           act = ACT_LOAD;
        else if (up_rise_i && dn_rise_i) act = ACT_CLASH;
        else if (up_rise_i)           act = ACT_INC;
        else if (dn_rise_i)           act = ACT_DEC;
        else                          act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        if (up_rise_i && dn_rise_i) st_d.fault = 1'b1;
        unique case (act)
            ACT_CLEAR: st_d.count = '0;
            ACT_LOAD:  st_d.count = data_i;
            ACT_INC:   st_d.count = st_q.count + 1'b1;
            ACT_DEC:   st_d.count = st_q.count - 1'b1;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign fault_o = st_q.fault;
endmodule

// File: rtl/dual_clock_counter.sv
`timescale 1ns/1ps
module dual_clock_counter #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_strobe_i,
    input  logic             dn_strobe_i,
    input  logic             clear_i,
    input  logic             load_n_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_n_o,
    output logic             borrow_n_o,
    output logic             fault_o
);
    localparam logic [WIDTH-1:0] TOP_VAL = '1;
    localparam int NSTROBE = 2;

    logic [NSTROBE-1:0] raw_s, lvl_s, rise_s;
    logic up_rise, dn_rise, up_lvl, dn_lvl;

    assign raw_s = {dn_strobe_i, up_strobe_i};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
        dcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_s[g]),
            .level_o (lvl_s[g]),
            .rise_o  (rise_s[g])
        );
    end

    assign up_rise = rise_s[0];
    assign dn_rise = rise_s[1];
    assign up_lvl  = lvl_s[0];
    assign dn_lvl  = lvl_s[1];

    dcc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .load_n_i  (load_n_i),
        .data_i    (data_i),
        .up_rise_i (up_rise),
        .dn_rise_i (dn_rise),
        .count_o   (count_o),
        .fault_o   (fault_o)
    );

    assign carry_n_o  = ~((count_o == TOP_VAL) & ~up_lvl);
    assign borrow_n_o = ~((count_o == '0) & ~dn_lvl);
endmodule

// File: rtl/dcc_chk.sv
`timescale 1ns/1ps
module dcc_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             load_n_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] count_o,
    input logic             carry_n_o,
    input logic             borrow_n_o,
    input logic             fault_o,
    input logic             up_rise,
    input logic             dn_rise
);
    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0));

    // R5
    preset_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_n_i) |=> (count_o == $past(data_i)));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && up_rise && !dn_rise) |=> (count_o == WIDTH'($past(count_o) + 1)));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && dn_rise && !up_rise) |=> (count_o == WIDTH'($past(count_o) - 1)));

    // R9
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && load_n_i && up_rise && dn_rise) |=> ($stable(count_o) && fault_o));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R6
    carry_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n_o |-> (count_o == '1));

    // R7
    borrow_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n_o |-> (count_o == '0));
endmodule

bind dual_clock_counter dcc_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .load_n_i   (load_n_i),
    .data_i     (data_i),
    .count_o    (count_o),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o),
    .fault_o    (fault_o),
    .up_rise    (up_rise),
    .dn_rise    (dn_rise)
);

// File: tb/sim_dual_clock_counter.sv
`timescale 1ns/1ps
module sim_dual_clock_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_s = 1'b1, dn_s = 1'b1, clr = 1'b0, ld_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic c0, b0, c1, b1, f0, f1;
    logic [7:0] model;
    int n_run = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_clock_counter u0 (
        .clk(clk), .rst_n(rst_n), .up_strobe_i(up_s), .dn_strobe_i(dn_s),
        .clear_i(clr), .load_n_i(ld_n), .data_i(din[3:0]),
        .count_o(q_lo), .carry_n_o(c0), .borrow_n_o(b0), .fault_o(f0));

    dual_clock_counter u1 (
        .clk(clk), .rst_n(rst_n), .up_strobe_i(c0), .dn_strobe_i(b0),
        .clear_i(clr), .load_n_i(ld_n), .data_i(din[7:4]),
        .count_o(q_hi), .carry_n_o(c1), .borrow_n_o(b1), .fault_o(f1));

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    task automatic pulse_up();
        up_s = 1'b0;
        wait_n(6);
        chk("R6 carry low phase", c0, (model[3:0] == 4'hF) ? 0 : 1);
        up_s = 1'b1;
        model = model + 8'd1;
        wait_n(8);
        chk("R2/R10 up count", {q_hi, q_lo}, model);
        chk("R6 carry idle", c0, 1);
    endtask

    task automatic pulse_dn();
        dn_s = 1'b0;
        wait_n(6);
        chk("R7 borrow low phase", b0, (model[3:0] == 4'h0) ? 0 : 1);
        dn_s = 1'b1;
        model = model - 8'd1;
        wait_n(8);
        chk("R3/R10 down count", {q_hi, q_lo}, model);
        chk("R7 borrow idle", b0, 1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        wait_n(3);
        // R1 reset state
        chk("R1 count", {q_hi, q_lo}, 0);
        chk("R1 carry", c0, 1);
        chk("R1 borrow", b0, 1);
        chk("R1 fault", f0, 0);
        rst_n = 1'b1;
        wait_n(3);
        chk("R1 count after release", {q_hi, q_lo}, 0);
        model = 8'h00;

        // R2 R10 upward sweep across the 255->0 wrap
        for (int i = 0; i < 260; i++) pulse_up();
        // R3 R10 downward sweep across the 0->255 wrap
        for (int i = 0; i < 270; i++) pulse_dn();

        // R5 preset, strobes ignored while preset held
        din = 8'h37; ld_n = 1'b0;
        wait_n(2);
        up_s = 1'b0; wait_n(5); up_s = 1'b1; wait_n(5);
        chk("R5 preset holds", {q_hi, q_lo}, 8'h37);
        ld_n = 1'b1; wait_n(8);
        chk("R5 after release", {q_hi, q_lo}, 8'h37);
        model = 8'h37;

        // R4 clear beats preset
        din = 8'h5A; ld_n = 1'b0; clr = 1'b1;
        wait_n(2);
        chk("R4 clear over preset", {q_hi, q_lo}, 0);
        ld_n = 1'b1; clr = 1'b0; wait_n(8);
        chk("R4 after release", {q_hi, q_lo}, 0);

        // R8 up strobe low across preset release
        up_s = 1'b0; din = 8'hFE; ld_n = 1'b0; wait_n(3);
        ld_n = 1'b1; wait_n(4);
        up_s = 1'b1; wait_n(8);
        chk("R8 edge after preset", {q_hi, q_lo}, 8'hFF);

        // R8 down strobe low across clear release
        dn_s = 1'b0; clr = 1'b1; wait_n(3);
        clr = 1'b0; wait_n(4);
        chk("R7 borrow at zero", b0, 0);
        dn_s = 1'b1; wait_n(8);
        chk("R8 edge after clear", {q_hi, q_lo}, 8'hFF);
        model = 8'hFF;

        // R9 simultaneous edges on stage 0
        din = 8'h04; ld_n = 1'b0; wait_n(2); ld_n = 1'b1; wait_n(2);
        up_s = 1'b0; dn_s = 1'b0; wait_n(6);
        up_s = 1'b1; dn_s = 1'b1; wait_n(8);
        chk("R9 count held", q_lo, 4'h4);
        chk("R9 fault set", f0, 1);
        model = 8'h04;
        pulse_up();
        chk("R9 fault sticky", f0, 1);
        clr = 1'b1; wait_n(2); clr = 1'b0; wait_n(2);
        chk("R9 fault survives clear", f0, 1);
        rst_n = 1'b0; wait_n(2); rst_n = 1'b1; wait_n(2);
        chk("R9 fault cleared by reset", f0, 0);

        done = 1;
        report();
    end
endmodule